// File: doc/BRIEF.md
# Per-Lane Variable Logical Right Shifter

This SIMD datapath unit shifts every element of a packed 256-bit source vector right, filling with zeros. Each element has its own shift count, taken from the element in the same position of a second packed 256-bit vector. A lane-size control selects one of two lane layouts:

- eight 32-bit lanes, or
- four 64-bit lanes.

A width control selects whether the operation covers 128 or 256 bits.

The whole lane value is read as an unsigned count. Any count equal to or larger than the lane width clears that lane. The count does not wrap, and its upper bits are not masked off.

The unit sits in an execute stage. By default the result goes through one output register, which updates only when the input valid strobe is high. Setting the parameter `REG_OUT` to 0 makes the path purely combinational.

Top module: `vshr_unit`

## Requirements
- R1: With `lane64_i`=0, lane k occupies bits [32k+31:32k] of `src_i`, `cnt_i` and `res_o`. With `lane64_i`=1, lane k occupies bits [64k+63:64k]. Each lane of `res_o` is that source lane shifted right by its own count, with zeros filled in at the top, independently of the other lanes.
- R2: In 32-bit lane mode, a lane whose 32-bit count read as unsigned is above 31 produces zero. This holds even when the low five bits of the count are small.
- R3: In 64-bit lane mode, a lane whose 64-bit count read as unsigned is above 63 produces zero. This holds even when the low six bits of the count are small.
- R4: A count of 0 passes the lane through unchanged. A count of lane width minus 1 leaves only the lane's top bit, moved to the lane's bit 0.
- R5: With `wide_i`=0 (128-bit width), `res_o[255:128]` is zero and the lower 128 bits follow R1 to R4.
- R6: With `wide_i`=1 (256-bit width), all lanes are processed, eight in 32-bit mode and four in 64-bit mode.
- R7: With `REG_OUT`=1, `res_o` and `valid_o` reflect the inputs sampled at the rising clock edge where `valid_i` was high, so the latency is one cycle. `valid_o` is low one cycle after `valid_i` is low.
- R8: With `REG_OUT`=1, a cycle with `valid_i` low leaves `res_o` unchanged, whatever the other inputs do.
- R9: While `rst_ni` is low, `res_o` and `valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid |
| lane64_i | input | 1 | Lane size: 0 = 32-bit, 1 = 64-bit |
| wide_i | input | 1 | Operation width: 0 = 128-bit, 1 = 256-bit |
| src_i | input | 256 | Packed data to shift |
| cnt_i | input | 256 | Packed per-lane unsigned counts |
| res_o | output | 256 | Packed shifted result |
| valid_o | output | 1 | Result valid |

## Verification
Two zeroing causes can land in the same operation: out-of-range count clearing and upper-half clearing at 128-bit width. The bench provokes both at once with narrow-width vectors. In these vectors the lower lanes carry counts just past the lane width or with high bits set, while the upper lanes carry small in-range counts. A correct result has the lower lanes cleared only where their count is out of range, and the upper half cleared regardless of its counts. Sweeps over every count from zero to past the lane width, in both lane sizes and both widths, are compared lane by lane against an arithmetic model in the bench.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  localparam int unsigned NARROW_LANE_W = 32;
  localparam int unsigned WIDE_LANE_W   = 64;

  typedef enum logic {
    LANE_32 = 1'b0,
    LANE_64 = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/vshr_lane.sv
module vshr_lane #(
  parameter int unsigned LW = 32
) (
  input  logic [LW-1:0] data_i,
  input  logic [LW-1:0] cnt_i,
  output logic [LW-1:0] res_o
);
  localparam int unsigned SW = $clog2(LW);

  logic over_range;
  // any bit at or above log2(LW) means count >= LW
  assign over_range = |cnt_i[LW-1:SW];
  assign res_o      = over_range ? '0 : (data_i >> cnt_i[SW-1:0]);
endmodule

// File: rtl/vshr_out_stage.sv
module vshr_out_stage #(
  parameter int unsigned W       = 256,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o     <= '0;
        valid_o <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) q_o <= d_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o        = d_i;
    assign valid_o    = valid_i;
  end
endmodule

// File: rtl/vshr_unit.sv
module vshr_unit #(
  parameter int unsigned VEC_W   = 256,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             lane64_i,
  input  logic             wide_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] cnt_i,
  output logic [VEC_W-1:0] res_o,
  output logic             valid_o
);
  import vshr_pkg::*;

  localparam int unsigned N_NARROW = VEC_W / NARROW_LANE_W;
  localparam int unsigned N_WIDE   = VEC_W / WIDE_LANE_W;
  localparam int unsigned HALF_W   = VEC_W / 2;

  logic [VEC_W-1:0] res_narrow, res_wide, res_sel, res_masked;

  for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
    vshr_lane #(.LW(NARROW_LANE_W)) i_lane (
      .data_i(src_i[k*NARROW_LANE_W +: NARROW_LANE_W]),
      .cnt_i (cnt_i[k*NARROW_LANE_W +: NARROW_LANE_W]),
      .res_o (res_narrow[k*NARROW_LANE_W +: NARROW_LANE_W])
    );
  end

  for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
    vshr_lane #(.LW(WIDE_LANE_W)) i_lane (
      .data_i(src_i[k*WIDE_LANE_W +: WIDE_LANE_W]),
      .cnt_i (cnt_i[k*WIDE_LANE_W +: WIDE_LANE_W]),
      .res_o (res_wide[k*WIDE_LANE_W +: WIDE_LANE_W])
    );
  end

  assign res_sel = (lane_mode_e'(lane64_i) == LANE_64) ? res_wide : res_narrow;

  always_comb begin
    res_masked = res_sel;
    if (!wide_i) res_masked[VEC_W-1:HALF_W] = '0;
  end

  vshr_out_stage #(.W(VEC_W), .REG_OUT(REG_OUT)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .d_i    (res_masked),
    .q_o    (res_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/vshr_unit_chk.sv
module vshr_unit_chk #(
  parameter int unsigned VEC_W   = 256,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             lane64_i,
  input logic             wide_i,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] cnt_i,
  input logic [VEC_W-1:0] res_o,
  input logic             valid_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  if (REG_OUT) begin : g_seq
    p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_valid_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(res_o));
    p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wide_i) |=> (res_o[VEC_W-1:HALF_W] == '0));
    p_big_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !lane64_i && (cnt_i[31:0] > 32'd31)) |=> (res_o[31:0] == '0));
    p_big_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && lane64_i && (cnt_i[63:0] > 64'd63)) |=> (res_o[63:0] == '0));
    p_zero_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !lane64_i && (cnt_i[31:0] == '0)) |=> (res_o[31:0] == $past(src_i[31:0])));
  end else begin : g_comb
    always_comb begin
      if (valid_i && !wide_i) a_upper_zero_r5: assert (res_o[VEC_W-1:HALF_W] == '0);
      a_valid_pass_r7: assert (valid_o == valid_i);
    end
  end

  always_comb begin
    if (!rst_ni && REG_OUT) a_reset_r9: assert (res_o == '0 && !valid_o);
  end
endmodule

bind vshr_unit vshr_unit_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .lane64_i(lane64_i),
  .wide_i(wide_i), .src_i(src_i), .cnt_i(cnt_i), .res_o(res_o), .valid_o(valid_o)
);

// File: tb/test_vshr_unit.sv
module test_vshr_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         lane64_i = 1'b0;
  logic         wide_i = 1'b0;
  logic [255:0] src_i = '0;
  logic [255:0] cnt_i = '0;
  logic [255:0] res_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  vshr_unit i_vshr_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .lane64_i(lane64_i),
    .wide_i(wide_i), .src_i(src_i), .cnt_i(cnt_i), .res_o(res_o), .valid_o(valid_o)
  );

  function automatic logic [255:0] ref_model(input logic [255:0] s, input logic [255:0] c,
                                             input logic l64, input logic wd);
    logic [255:0] r;
    int lw;
    r  = '0;
    lw = l64 ? 64 : 32;
    for (int k = 0; k < 256 / lw; k++) begin
      logic [63:0] d, n, o;
      d = '0;
      n = '0;
      for (int b = 0; b < lw; b++) begin
        d[b] = s[k*lw+b];
        n[b] = c[k*lw+b];
      end
      o = (n >= 64'(lw)) ? 64'd0 : (d >> n);
      for (int b = 0; b < lw; b++) r[k*lw+b] = o[b];
    end
    if (!wd) r[255:128] = '0;
    return r;
  endfunction

  function automatic logic [255:0] fill(input int lw, input logic [63:0] c);
    logic [255:0] v;
    v = '0;
    for (int k = 0; k < 256 / lw; k++)
      for (int b = 0; b < lw; b++) v[k*lw+b] = c[b];
    return v;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [255:0] s, input logic [255:0] c,
                         input logic l64, input logic wd, input string tag_lo);
    logic [255:0] exp;
    @(negedge clk_i);
    src_i = s; cnt_i = c; lane64_i = l64; wide_i = wd; valid_i = 1'b1;
    exp = ref_model(s, c, l64, wd);
    @(posedge clk_i);
    #1;
    chk(tag_lo, {128'd0, res_o[127:0]}, {128'd0, exp[127:0]});
    chk(wd ? "R6" : "R5", {res_o[255:128], 128'd0}, {exp[255:128], 128'd0});
    chk("R7", {255'd0, valid_o}, 256'd1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] last;
    string tag;
    int lw;
    // R9: reset state
    src_i = '1; cnt_i = '0; valid_i = 1'b1; wide_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R9", res_o, '0);
    chk("R9", {255'd0, valid_o}, '0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // count sweeps, both lane sizes, both widths
    for (int m = 0; m < 2; m++) begin
      lw = m ? 64 : 32;
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c <= lw + 8; c++) begin
          if (c >= lw) tag = m ? "R3" : "R2";
          else if (c == 0 || c == lw - 1) tag = "R4";
          else tag = "R1";
          run_vec(rnd256(), fill(lw, 64'(c)), m[0], w[0], tag);
        end
        // R4: all ones data, count lw-1 leaves a single 1 per lane
        run_vec('1, fill(lw, 64'(lw - 1)), m[0], w[0], "R4");
      end
    end

    // R2: high count bits set, low bits in range
    run_vec(rnd256(), fill(32, 64'h0000_0000_0000_0103), 1'b0, 1'b1, "R2");
    run_vec(rnd256(), fill(32, 64'h0000_0000_8000_0000), 1'b0, 1'b1, "R2");
    // R3: high count bits set, low bits in range
    run_vec(rnd256(), fill(64, 64'h0000_0001_0000_0005), 1'b1, 1'b1, "R3");
    run_vec(rnd256(), fill(64, 64'h8000_0000_0000_0000), 1'b1, 1'b1, "R3");

    // R1: per-lane distinct counts, independence of lanes
    for (int t = 0; t < 40; t++) begin
      logic [255:0] c;
      lw = t[0] ? 64 : 32;
      c = '0;
      for (int k = 0; k < 256 / lw; k++) begin
        logic [63:0] v;
        v = 64'((t * 5 + k * 11) % (lw + 6));
        if (k == 1 && t[1]) v = v | (64'd1 << (lw - 1));
        for (int b = 0; b < lw; b++) c[k*lw+b] = v[b];
      end
      run_vec(rnd256(), c, t[0], t[2], "R1");
    end

    // R5 with R2/R3 in the same cycle: over-range low lanes, in-range high lanes, narrow width
    for (int m = 0; m < 2; m++) begin
      logic [255:0] c;
      lw = m ? 64 : 32;
      c = fill(lw, 64'd3);
      for (int b = 0; b < lw; b++) c[b] = (b == 0 || b == lw - 2);
      run_vec(rnd256(), c, m[0], 1'b0, m ? "R3" : "R2");
    end

    // R8: valid low with changed inputs holds the result
    run_vec(rnd256(), fill(32, 64'd4), 1'b0, 1'b1, "R1");
    last = res_o;
    @(negedge clk_i);
    valid_i = 1'b0; src_i = rnd256(); cnt_i = '0; lane64_i = 1'b1; wide_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R8", res_o, last);
    chk("R7", {255'd0, valid_o}, '0);
    @(posedge clk_i);
    #1;
    chk("R8", res_o, last);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule